// File: doc/BRIEF.md
# SD Card SPI-Mode Target Responder

This block plays the card side of an SD card in SPI mode at byte level. A host-facing byte exchanger hands it one byte together with a one-cycle strobe. The block returns exactly one response byte per exchange on the following cycle. Bit shifting on the serial wires is handled elsewhere, so this block sees only whole bytes.

After reset, the block first counts a fixed number of wake-up exchanges. It then follows the command-based initialization handshake and, once ready, serves single-block reads and writes of 512 bytes. The data lives in a small on-chip block store. A five-slot response queue carries command replies, start tokens, CRC bytes and data-response bytes, and it always wins over any other activity. Data blocks are protected by CRC16 (polynomial 0x1021, initial value 0).

Top module: `sdspi_card`

## Requirements
- R1: After reset `resp_valid` is 0 and `resp_byte` is 0xFF. Every strobe on `xfer_valid` yields exactly one `resp_valid` pulse in the next cycle, and no pulse appears without a strobe. An exchange with nothing to return yields 0xFF.
- R2: The first 8 exchanges after reset only advance the wake count: they answer 0xFF and are never decoded, even when they look like commands.
- R3: When no command is partly collected, a byte outside 0x40..0x7F is dropped and does not begin a command.
- R4: A command is 6 bytes: an opcode byte whose low 6 bits are the index, a 32-bit argument sent most significant byte first, and a check byte that is ignored. The command is decoded after its sixth byte, and its reply starts on the next exchange.
- R5: The initialization order is strict, and each step has a fixed reply. From the woken state, index 0 answers 0x01. Next, index 8 with argument 0x000001AA answers the five bytes 0x01 0x00 0x00 0x01 0xAA. Next, index 55 answers 0x01. Finally, index 41 answers 0x00, and the card stays ready until reset.
- R6: During initialization, any command other than the one expected sends the state back to woken and queues no reply.
- R7: While queued bytes remain, each exchange returns the next slot. The incoming byte is discarded and is not collected as command data.
- R8: When ready, index 17 answers 0x00 then 0xFE. It then returns the 512 bytes of block (argument mod NUM_BLOCKS), one byte per exchange, followed by the two CRC bytes with the high byte first.
- R9: The CRC16 uses polynomial 0x1021, MSB first, with initial value 0. It is cleared at the start of each read or write data phase.
- R10: When ready, index 24 answers 0x00 and then waits for a token. A 0xFF byte is skipped, a 0xFE byte opens the data phase, and any other byte cancels the write, leaving the card idle.
- R11: In the write data phase, 512 bytes are stored to the selected block, and then two CRC bytes (high byte first) are taken. The next exchange returns 0x05 if the CRC matches the CRC over the stored data, and 0x0B if it does not.
- R12: When ready, any other command index answers 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_valid | input | 1 | One-cycle strobe: an exchange byte is present |
| xfer_byte | input | 8 | Byte sent by the host in this exchange |
| resp_valid | output | 1 | Pulses one cycle after each strobe |
| resp_byte | output | 8 | Byte returned for the latest exchange |

## Verification
The assertions assume that `xfer_valid` and `xfer_byte` are known from the first edge after reset. They also assume that the host consumes each reply one cycle after its strobe. The bench drives strobes only on the falling edge and leaves an idle cycle between exchanges. It always finishes every data phase it opens, sending the full 512 data bytes and both CRC bytes, before issuing another command. The checker's wake window counts strobes itself, so it does not depend on the bench's pacing.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;

  typedef enum logic [2:0] {
    INI_WOKEN = 3'd0,
    INI_GOT0  = 3'd1,
    INI_GOT8  = 3'd2,
    INI_GOT55 = 3'd3,
    INI_READY = 3'd4
  } init_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_READ   = 2'd1,
    PH_WTOKEN = 2'd2,
    PH_WDATA  = 2'd3
  } phase_e;

  localparam logic [7:0] BYTE_IDLE   = 8'hFF;
  localparam logic [7:0] BYTE_TOKEN  = 8'hFE;
  localparam logic [7:0] R1_IDLE     = 8'h01;
  localparam logic [7:0] R1_OK       = 8'h00;
  localparam logic [7:0] DR_ACCEPT   = 8'h05;
  localparam logic [7:0] DR_CRC_BAD  = 8'h0B;

  localparam logic [7:0] OP_RESET    = 8'h40;
  localparam logic [7:0] OP_IFCOND   = 8'h48;
  localparam logic [7:0] OP_APPCMD   = 8'h77;
  localparam logic [7:0] OP_OPCOND   = 8'h69;
  localparam logic [7:0] OP_RDBLK    = 8'h51;
  localparam logic [7:0] OP_WRBLK    = 8'h58;

  localparam logic [31:0] IFCOND_ARG = 32'h0000_01AA;

endpackage

// File: rtl/sdspi_crc16.sv
module sdspi_crc16 #(
  parameter logic [15:0] POLY = 16'h1021
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc,
  output logic [15:0] crc_nxt
);

  logic [15:0] crc_q, crc_d;

  // byte-wide update, MSB first
  always_comb begin
    logic [15:0] c;
    c = crc_q;
    for (int i = 7; i >= 0; i--) begin
      if (c[15] ^ din[i]) c = {c[14:0], 1'b0} ^ POLY;
      else                c = {c[14:0], 1'b0};
    end
    crc_nxt = c;
  end

  always_comb begin
    crc_d = crc_q;
    if (clr)     crc_d = '0;
    else if (en) crc_d = crc_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;

endmodule

// File: rtl/sdspi_blkmem.sv
module sdspi_blkmem #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sdspi_card.sv
module sdspi_card
  import sdspi_pkg::*;
#(
  parameter int NUM_BLOCKS = 2,
  parameter int BLK_BYTES  = 512,
  parameter int WAKE_COUNT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xfer_valid,
  input  logic [7:0] xfer_byte,
  output logic       resp_valid,
  output logic [7:0] resp_byte
);

  localparam int BLK_BITS = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;
  localparam int OFF_W    = $clog2(BLK_BYTES);
  localparam int CNT_W    = $clog2(BLK_BYTES + 2);
  localparam int ADDR_W   = BLK_BITS + OFF_W;
  localparam int WAKE_W   = $clog2(WAKE_COUNT + 1);

  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(BLK_BYTES - 1);
  localparam logic [CNT_W-1:0]  CNT_CRCH = CNT_W'(BLK_BYTES);
  localparam logic [WAKE_W-1:0] WAKE_END = WAKE_W'(WAKE_COUNT);

  // state
  logic [WAKE_W-1:0]   wake_q, wake_d;
  init_e               init_q, init_d;
  phase_e              phase_q, phase_d;
  logic [4:0][7:0]     cbuf_q, cbuf_d;
  logic [2:0]          cidx_q, cidx_d;
  logic [4:0][7:0]     slot_q, slot_d;
  logic                q_busy_q, q_busy_d;
  logic [2:0]          q_idx_q, q_idx_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [BLK_BITS-1:0] blk_q, blk_d;
  logic [7:0]          whi_q, whi_d;
  logic [7:0]          resp_q, resp_d;
  logic                rvld_q, rvld_d;

  // datapath links
  logic        crc_clr, crc_en;
  logic [7:0]  crc_din;
  logic [15:0] crc_cur, crc_nxt;
  logic        mem_we;
  logic [7:0]  mem_rdata;
  logic [ADDR_W-1:0] mem_addr;

  logic [7:0]  op_byte;
  logic [31:0] cmd_arg;

  assign op_byte  = cbuf_q[0];
  assign cmd_arg  = {cbuf_q[1], cbuf_q[2], cbuf_q[3], cbuf_q[4]};
  assign mem_addr = {blk_q, cnt_q[OFF_W-1:0]};

  sdspi_crc16 #(.POLY(16'h1021)) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (crc_clr),
    .en      (crc_en),
    .din     (crc_din),
    .crc     (crc_cur),
    .crc_nxt (crc_nxt)
  );

  sdspi_blkmem #(.ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_addr),
    .wdata (xfer_byte),
    .raddr (mem_addr),
    .rdata (mem_rdata)
  );

  // next-state logic
  always_comb begin
    logic [7:0] rsp;
    wake_d   = wake_q;
    init_d   = init_q;
    phase_d  = phase_q;
    cbuf_d   = cbuf_q;
    cidx_d   = cidx_q;
    slot_d   = slot_q;
    q_busy_d = q_busy_q;
    q_idx_d  = q_idx_q;
    cnt_d    = cnt_q;
    blk_d    = blk_q;
    whi_d    = whi_q;
    resp_d   = resp_q;
    rvld_d   = 1'b0;
    crc_clr  = 1'b0;
    crc_en   = 1'b0;
    crc_din  = xfer_byte;
    mem_we   = 1'b0;
    rsp      = BYTE_IDLE;

    if (xfer_valid) begin
      rvld_d = 1'b1;
      if (wake_q != WAKE_END) begin
        wake_d = wake_q + 1'b1;
      end else if (q_busy_q) begin
        rsp = slot_q[q_idx_q];
        if (q_idx_q == 3'd4) q_busy_d = 1'b0;
        else                 q_idx_d  = q_idx_q + 3'd1;
      end else begin
        case (phase_q)
          PH_READ: begin
            rsp     = mem_rdata;
            crc_en  = 1'b1;
            crc_din = mem_rdata;
            if (cnt_q == CNT_LAST) begin
              slot_d[3] = crc_nxt[15:8];
              slot_d[4] = crc_nxt[7:0];
              q_idx_d   = 3'd3;
              q_busy_d  = 1'b1;
              phase_d   = PH_IDLE;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          PH_WTOKEN: begin
            if (xfer_byte == BYTE_TOKEN) begin
              phase_d = PH_WDATA;
              cnt_d   = '0;
              crc_clr = 1'b1;
            end else if (xfer_byte != BYTE_IDLE) begin
              phase_d = PH_IDLE;
            end
          end
          PH_WDATA: begin
            if (cnt_q < CNT_CRCH) begin
              mem_we = 1'b1;
              crc_en = 1'b1;
              cnt_d  = cnt_q + 1'b1;
            end else if (cnt_q == CNT_CRCH) begin
              whi_d = xfer_byte;
              cnt_d = cnt_q + 1'b1;
            end else begin
              slot_d[4] = ({whi_q, xfer_byte} == crc_cur) ? DR_ACCEPT : DR_CRC_BAD;
              q_idx_d   = 3'd4;
              q_busy_d  = 1'b1;
              phase_d   = PH_IDLE;
            end
          end
          default: begin
            if (cidx_q == 3'd0 && xfer_byte[7:6] != 2'b01) begin
              // not a command opener: dropped
            end else if (cidx_q != 3'd5) begin
              cbuf_d[cidx_q] = xfer_byte;
              cidx_d         = cidx_q + 3'd1;
            end else begin
              cidx_d = 3'd0;
              case (init_q)
                INI_WOKEN: begin
                  if (op_byte == OP_RESET) begin
                    init_d    = INI_GOT0;
                    slot_d[4] = R1_IDLE;
                    q_idx_d   = 3'd4;
                    q_busy_d  = 1'b1;
                  end
                end
                INI_GOT0: begin
                  if (op_byte == OP_IFCOND && cmd_arg == IFCOND_ARG) begin
                    init_d   = INI_GOT8;
                    slot_d   = {IFCOND_ARG[7:0], IFCOND_ARG[15:8], IFCOND_ARG[23:16],
                                IFCOND_ARG[31:24], R1_IDLE};
                    q_idx_d  = 3'd0;
                    q_busy_d = 1'b1;
                  end else begin
                    init_d = INI_WOKEN;
                  end
                end
                INI_GOT8: begin
                  if (op_byte == OP_APPCMD) begin
                    init_d    = INI_GOT55;
                    slot_d[4] = R1_IDLE;
                    q_idx_d   = 3'd4;
                    q_busy_d  = 1'b1;
                  end else begin
                    init_d = INI_WOKEN;
                  end
                end
                INI_GOT55: begin
                  if (op_byte == OP_OPCOND) begin
                    init_d    = INI_READY;
                    slot_d[4] = R1_OK;
                    q_idx_d   = 3'd4;
                    q_busy_d  = 1'b1;
                  end else begin
                    init_d = INI_WOKEN;
                  end
                end
                INI_READY: begin
                  q_busy_d = 1'b1;
                  if (op_byte == OP_RDBLK) begin
                    slot_d[3] = R1_OK;
                    slot_d[4] = BYTE_TOKEN;
                    q_idx_d   = 3'd3;
                    phase_d   = PH_READ;
                    cnt_d     = '0;
                    blk_d     = cmd_arg[BLK_BITS-1:0];
                    crc_clr   = 1'b1;
                  end else if (op_byte == OP_WRBLK) begin
                    slot_d[4] = R1_OK;
                    q_idx_d   = 3'd4;
                    phase_d   = PH_WTOKEN;
                    blk_d     = cmd_arg[BLK_BITS-1:0];
                  end else begin
                    slot_d[4] = R1_OK;
                    q_idx_d   = 3'd4;
                  end
                end
                default: init_d = INI_WOKEN;
              endcase
            end
          end
        endcase
      end
      resp_d = rsp;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q   <= '0;
      init_q   <= INI_WOKEN;
      phase_q  <= PH_IDLE;
      cbuf_q   <= '0;
      cidx_q   <= '0;
      slot_q   <= '0;
      q_busy_q <= 1'b0;
      q_idx_q  <= '0;
      cnt_q    <= '0;
      blk_q    <= '0;
      whi_q    <= '0;
      resp_q   <= BYTE_IDLE;
      rvld_q   <= 1'b0;
    end else begin
      wake_q   <= wake_d;
      init_q   <= init_d;
      phase_q  <= phase_d;
      cbuf_q   <= cbuf_d;
      cidx_q   <= cidx_d;
      slot_q   <= slot_d;
      q_busy_q <= q_busy_d;
      q_idx_q  <= q_idx_d;
      cnt_q    <= cnt_d;
      blk_q    <= blk_d;
      whi_q    <= whi_d;
      resp_q   <= resp_d;
      rvld_q   <= rvld_d;
    end
  end

  assign resp_valid = rvld_q;
  assign resp_byte  = resp_q;

endmodule

// File: rtl/sdspi_card_chk.sv
module sdspi_card_chk #(
  parameter int WAKE_COUNT = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       xfer_valid,
  input logic       resp_valid,
  input logic [7:0] resp_byte,
  input logic [2:0] init_st,
  input logic [1:0] phase,
  input logic       q_busy,
  input logic [2:0] q_idx
);

  localparam int SEEN_W = $clog2(WAKE_COUNT + 1);

  logic [SEEN_W-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                           seen_q <= '0;
    else if (xfer_valid && seen_q != SEEN_W'(WAKE_COUNT)) seen_q <= seen_q + 1'b1;
  end

  // R1
  resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |=> resp_valid);

  // R1
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_valid |=> !resp_valid);

  // R2
  wake_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && seen_q != SEEN_W'(WAKE_COUNT)) |=> (resp_byte == 8'hFF));

  // R5
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_st == 3'd4) |=> (init_st == 3'd4));

  // R8
  read_reply_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase == 2'd1) |-> q_busy);

  // R7
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_busy |-> (q_idx <= 3'd4));

endmodule

bind sdspi_card sdspi_card_chk #(.WAKE_COUNT(WAKE_COUNT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xfer_valid (xfer_valid),
  .resp_valid (resp_valid),
  .resp_byte  (resp_byte),
  .init_st    (init_q),
  .phase      (phase_q),
  .q_busy     (q_busy_q),
  .q_idx      (q_idx_q)
);

// File: tb/test_sdspi_card.sv
module test_sdspi_card;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xfer_valid = 1'b0;
  logic [7:0] xfer_byte = 8'h00;
  logic       resp_valid;
  logic [7:0] resp_byte;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  sdspi_card i_sdspi_card (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_valid (xfer_valid),
    .xfer_byte  (xfer_byte),
    .resp_valid (resp_valid),
    .resp_byte  (resp_byte)
  );

  function automatic logic [15:0] ref_crc(logic [15:0] c, logic [7:0] d);
    logic [15:0] x;
    x = c ^ {d, 8'h00};
    for (int k = 0; k < 8; k++) x = x[15] ? ((x << 1) ^ 16'h1021) : (x << 1);
    return x;
  endfunction

  function automatic logic [7:0] pat_a(int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  function automatic logic [7:0] pat_b(int i);
    return 8'(i & 255) ^ 8'h5A;
  endfunction

  // monitor: pops expected replies
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1 extra reply act=%h exp=none", resp_byte);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (resp_byte !== e) begin
          errors++;
          $display("FAIL %s act=%h exp=%h", t, resp_byte, e);
        end
      end
    end
  end

  // driver
  task automatic xchg(input logic [7:0] b, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    xfer_byte  = b;
    xfer_valid = 1'b1;
    @(negedge clk);
    xfer_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_cmd(input int idx, input logic [31:0] arg, input string t);
    xchg({2'b01, 6'(idx)}, 8'hFF, t);
    xchg(arg[31:24], 8'hFF, t);
    xchg(arg[23:16], 8'hFF, t);
    xchg(arg[15:8],  8'hFF, t);
    xchg(arg[7:0],   8'hFF, t);
    xchg(8'h95,      8'hFF, t);
  endtask

  task automatic ifcond_ok(input logic [7:0] fill, input string t);
    send_cmd(8, 32'h1AA, "R5 ifcond");
    xchg(fill, 8'h01, t);
    xchg(fill, 8'h00, t);
    xchg(fill, 8'h00, t);
    xchg(fill, 8'h01, t);
    xchg(fill, 8'hAA, t);
  endtask

  task automatic write_block(input int blk, input bit use_b, input bit bad_crc);
    logic [15:0] c;
    c = 16'h0000;
    send_cmd(24, 32'(blk), "R10 wr cmd");
    xchg(8'hFF, 8'h00, "R10 wr r1");
    xchg(8'hFF, 8'hFF, "R10 skip idle");
    xchg(8'hFF, 8'hFF, "R10 skip idle");
    xchg(8'hFE, 8'hFF, "R10 token");
    for (int i = 0; i < 512; i++) begin
      logic [7:0] d;
      d = use_b ? pat_b(i) : pat_a(i);
      c = ref_crc(c, d);
      xchg(d, 8'hFF, "R11 wr data");
    end
    if (bad_crc) c = ~c;
    xchg(c[15:8], 8'hFF, "R11 crc hi");
    xchg(c[7:0],  8'hFF, "R11 crc lo");
    xchg(8'hFF, bad_crc ? 8'h0B : 8'h05, "R11 data response");
  endtask

  task automatic read_block(input int arg, input bit use_b);
    logic [15:0] c;
    c = 16'h0000;
    send_cmd(17, 32'(arg), "R8 rd cmd");
    xchg(8'hFF, 8'h00, "R8 rd r1");
    xchg(8'hFF, 8'hFE, "R8 start token");
    for (int i = 0; i < 512; i++) begin
      logic [7:0] d;
      d = use_b ? pat_b(i) : pat_a(i);
      c = ref_crc(c, d);
      xchg(8'hFF, d, "R8 rd data");
    end
    xchg(8'hFF, c[15:8], "R9 crc hi");
    xchg(8'hFF, c[7:0],  "R9 crc lo");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (resp_valid !== 1'b0 || resp_byte !== 8'hFF) begin
      errors++;
      $display("FAIL R1 reset act=%b/%h exp=0/ff", resp_valid, resp_byte);
    end

    // R2: wake bytes, including a command-shaped frame
    send_cmd(0, 32'h0, "R2 wake");
    xchg(8'h40, 8'hFF, "R2 wake");
    xchg(8'h00, 8'hFF, "R2 wake");
    xchg(8'hFF, 8'hFF, "R2 no decode after wake");

    // R3: non-opener bytes dropped
    xchg(8'h12, 8'hFF, "R3 drop");
    xchg(8'hC0, 8'hFF, "R3 drop");

    // R6: ifcond while only woken
    send_cmd(8, 32'h1AA, "R6 early ifcond");
    xchg(8'hFF, 8'hFF, "R6 early ifcond no reply");

    // R4/R5: reset command
    send_cmd(0, 32'h0, "R4 frame");
    xchg(8'hFF, 8'h01, "R4 reset reply");

    // R6: wrong ifcond argument
    send_cmd(8, 32'h1AB, "R6 bad arg");
    xchg(8'hFF, 8'hFF, "R6 bad arg no reply");
    send_cmd(55, 32'h0, "R6 appcmd while woken");
    xchg(8'hFF, 8'hFF, "R6 woken no reply");

    // R7: bytes during queue emission are discarded
    send_cmd(0, 32'h0, "R5 reset");
    xchg(8'hFF, 8'h01, "R5 reset reply");
    ifcond_ok(8'h4D, "R7 queued reply");
    send_cmd(55, 32'h0, "R7 realigned");
    xchg(8'hFF, 8'h01, "R7 appcmd reply");

    // R6: deviation from the appcmd state
    send_cmd(0, 32'h0, "R6 out of order");
    xchg(8'hFF, 8'hFF, "R6 out of order no reply");

    // R5: full sequence
    send_cmd(0, 32'h0, "R5 reset");
    xchg(8'hFF, 8'h01, "R5 reset reply");
    ifcond_ok(8'hFF, "R5 ifcond reply");
    send_cmd(55, 32'h0, "R5 appcmd");
    xchg(8'hFF, 8'h01, "R5 appcmd reply");
    send_cmd(41, 32'h4000_0000, "R5 opcond");
    xchg(8'hFF, 8'h00, "R5 opcond reply");

    // R12
    send_cmd(13, 32'h0, "R12 other");
    xchg(8'hFF, 8'h00, "R12 other reply");
    send_cmd(0, 32'h0, "R12 reset when ready");
    xchg(8'hFF, 8'h00, "R12 reset when ready reply");

    // R10/R11: good write to block 1
    write_block(1, 1'b0, 1'b0);
    xchg(8'hFF, 8'hFF, "R1 idle after write");

    // R10: cancel
    send_cmd(24, 32'h0, "R10 cancel cmd");
    xchg(8'hFF, 8'h00, "R10 cancel r1");
    xchg(8'h33, 8'hFF, "R10 cancel byte");
    xchg(8'hFE, 8'hFF, "R10 token after cancel dropped");
    send_cmd(13, 32'h0, "R10 idle after cancel");
    xchg(8'hFF, 8'h00, "R10 command after cancel");

    // R11: bad crc write to block 0
    write_block(0, 1'b1, 1'b1);

    // R8/R9: reads, argument 3 maps to block 1
    read_block(3, 1'b0);
    read_block(0, 1'b1);
    xchg(8'hFF, 8'hFF, "R1 idle after read");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R1 missing replies act=%0d exp=0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule